// File: doc/BRIEF.md
# Multi-Dimensional Remap Index Generator

This block supplies a vector unit with a stream of remapped element numbers. It walks a three-level loop nest over dimensions X (innermost), Y and Z (outermost). Each step produces one linear index. The index is built by mixed-radix weighting of the three loop positions, and a base offset is added to the result. The shape is captured in a single cycle by a load pulse: three loop limits, an invert bit for each dimension, a selector that sets which dimension carries the smallest weight, and the offset.

With every index the block also gives a three-bit loop-end vector. Bit 0 marks the last X position. Bit 1 marks the last X and Y positions together. Bit 2 marks the last position of the whole nest. A consumer can use these bits to end an inner loop early or to close the complete schedule. The walk never stops. After the final combination it returns to the first one.

Top module: `remap_idx_gen`

## Requirements
- R1: While reset is high and after it, until the first load, outValid is 0, outIdx is 0 and loopEnd is 3'b111.
- R2: A load pulse captures the shape. On the next cycle outValid is 1 and the outputs show the first combination, with every loop position at 0. Each limit port carries the limit minus one, so 0 means 1 and 63 means 64.
- R3: A stepReq seen at a clock edge while outValid is 1 moves the walk on by exactly one combination. The outputs change on that edge. X advances on every step. Y advances when X wraps. Z advances when X and Y wrap together.
- R4: When no step is accepted, outIdx and loopEnd hold. This covers stepReq low, and stepReq high before any load.
- R5: outIdx equals (vLo + vMid*LLo + vHi*LLo*LMid) mod 128, plus the offset. Here v is a dimension's value and L is its limit. dimOrder gives the order from lowest to highest weight: 0=X,Y,Z 1=X,Z,Y 2=Y,X,Z 3=Y,Z,X 4=Z,X,Y 5=Z,Y,X.
- R6: invert bit 0 (X), bit 1 (Y) or bit 2 (Z) makes that dimension's value L-1-position, so it counts down from L-1 to 0.
- R7: The 7-bit baseOfs is added to the 7-bit weighted sum. The result goes on the 8-bit outIdx with no wrap.
- R8: loopEnd[0] is set when X is at its last position. loopEnd[1] needs X and Y at their last positions. loopEnd[2] needs all three at their last positions.
- R9: The step after the combination with loopEnd=3'b111 returns the walk to the first combination, and stepping goes on with no end.
- R10: A dimension of limit 1 is always at its last position. With X and Y at limit 1, loopEnd[1:0] reads 2'b11 on every combination.
- R11: A load restarts the walk from the first combination of the new shape, even while stepping is under way. A load takes priority over a stepReq in the same cycle.
- R12: dimOrder values 6 and 7 weight the dimensions in the same way as value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture the shape and restart the walk |
| limX | input | 6 | X limit minus one |
| limY | input | 6 | Y limit minus one |
| limZ | input | 6 | Z limit minus one |
| invert | input | 3 | Per-dimension count-down bits, bit 0 is X |
| dimOrder | input | 3 | Weight order selector |
| baseOfs | input | 7 | Offset added to every index |
| stepReq | input | 1 | Advance request, taken when outValid is 1 |
| outValid | output | 1 | Shape loaded, outputs meaningful |
| outIdx | output | 8 | Current remapped index |
| loopEnd | output | 3 | Cumulative loop-end flags |

## Verification
The hardest state to reach is the nest-end combination and the wrap that follows it. Getting there means stepping through every combination of the shape, and with an inverted dimension the last position is the one that reads 0. The stimulus uses short shapes, including limits of 1, so that complete walks stay brief. It walks each shape once past its final combination so the return to the start is seen. It repeats the walk for every order code, for mixed invert patterns, for a 64-long X dimension, and for a shape whose weighted sum passes 127.

// File: rtl/remap_pkg.sv
package remap_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic capture;
    logic advance;
  } strb_t;

  // returns {hi, mid, lo} dimension numbers for a weight order code
  function automatic logic [5:0] orderDims(input logic [2:0] sel);
    case (sel)
      3'd1:    orderDims = {2'd1, 2'd2, 2'd0};
      3'd2:    orderDims = {2'd2, 2'd0, 2'd1};
      3'd3:    orderDims = {2'd0, 2'd2, 2'd1};
      3'd4:    orderDims = {2'd1, 2'd0, 2'd2};
      3'd5:    orderDims = {2'd0, 2'd1, 2'd2};
      default: orderDims = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

endpackage

// File: rtl/remap_dim_ctr.sv
module remap_dim_ctr #(
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             capture,
  input  logic             inc,
  input  logic [LIM_W-1:0] limIn,
  output logic [LIM_W-1:0] pos,
  output logic [LIM_W-1:0] limQ,
  output logic             atEnd
);

  localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

  always_ff @(posedge clk) begin
    if (clear) begin
      pos  <= '0;
      limQ <= '0;
    end else if (capture) begin
      pos  <= '0;
      limQ <= limIn;
    end else if (inc) begin
      pos  <= atEnd ? '0 : pos + ONE;
    end
  end

  assign atEnd = (pos == limQ);

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (clear)
    pos <= limQ) else $error("position beyond limit"); // R3

endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  stepReq,
  output strb_t strb,
  output logic  outValid
);

  logic vld;

  always_ff @(posedge clk) begin
    if (rst)       vld <= 1'b0;
    else if (load) vld <= 1'b1;
  end

  always_comb begin
    strb.clear   = rst;
    strb.capture = load & ~rst;
    strb.advance = stepReq & vld & ~load & ~rst;
  end

  assign outValid = vld;

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> outValid) else $error("not valid after load"); // R2

endmodule

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int LIM_W = 6,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  strb_t            strb,
  input  logic [LIM_W-1:0] limX,
  input  logic [LIM_W-1:0] limY,
  input  logic [LIM_W-1:0] limZ,
  input  logic [2:0]       invert,
  input  logic [2:0]       dimOrder,
  input  logic [IDX_W-1:0] baseOfs,
  output logic [IDX_W:0]   outIdx,
  output logic [2:0]       loopEnd
);

  localparam int NDIM = 3;
  localparam int PW   = 2 * (LIM_W + 1);
  localparam int MW   = LIM_W + IDX_W;
  localparam logic [LIM_W:0]   ONE_L = (LIM_W+1)'(1);
  localparam logic [IDX_W-1:0] ONE_W = IDX_W'(1);
  localparam logic [LIM_W-1:0] ONE_P = LIM_W'(1);

  logic [NDIM-1:0][LIM_W-1:0] limIn, limQ, pos, vEff;
  logic [NDIM-1:0][IDX_W-1:0] weightQ, weightNext;
  logic [NDIM-1:0]            incV, endV;
  logic [NDIM-1:0][LIM_W:0]   limitV;
  logic [1:0]                 dLo, dMid, dHi;
  logic [PW-1:0]              wMidW, wHiW;
  logic [2:0]                 invQ;
  logic [IDX_W-1:0]           ofsQ, accSum;

  assign limIn[0] = limX;
  assign limIn[1] = limY;
  assign limIn[2] = limZ;

  // carry chain: each level advances when all inner levels wrap
  assign incV[0] = strb.advance;
  assign incV[1] = strb.advance & endV[0];
  assign incV[2] = strb.advance & endV[0] & endV[1];

  for (genvar g = 0; g < NDIM; g++) begin : gDim
    remap_dim_ctr #(.LIM_W(LIM_W)) uCtr (
      .clk     (clk),
      .clear   (strb.clear),
      .capture (strb.capture),
      .inc     (incV[g]),
      .limIn   (limIn[g]),
      .pos     (pos[g]),
      .limQ    (limQ[g]),
      .atEnd   (endV[g])
    );
    assign vEff[g] = invQ[g] ? (limQ[g] - pos[g]) : pos[g];
  end

  // weights are worked out once, at load time
  always_comb begin
    {dHi, dMid, dLo} = orderDims(dimOrder);
    for (int d = 0; d < NDIM; d++) limitV[d] = {1'b0, limIn[d]} + ONE_L;
    wMidW = {{(PW-LIM_W-1){1'b0}}, limitV[dLo]};
    wHiW  = wMidW * {{(PW-LIM_W-1){1'b0}}, limitV[dMid]};
    for (int d = 0; d < NDIM; d++) begin
      if (2'(d) == dLo)       weightNext[d] = ONE_W;
      else if (2'(d) == dMid) weightNext[d] = wMidW[IDX_W-1:0];
      else                    weightNext[d] = wHiW[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      invQ <= '0;
      ofsQ <= '0;
      for (int d = 0; d < NDIM; d++) weightQ[d] <= ONE_W;
    end else if (strb.capture) begin
      invQ    <= invert;
      ofsQ    <= baseOfs;
      weightQ <= weightNext;
    end
  end

  always_comb begin
    logic [MW-1:0] prod;
    accSum = '0;
    for (int d = 0; d < NDIM; d++) begin
      prod   = {{IDX_W{1'b0}}, vEff[d]} * {{LIM_W{1'b0}}, weightQ[d]};
      accSum = accSum + prod[IDX_W-1:0];
    end
  end

  assign outIdx  = {1'b0, accSum} + {1'b0, ofsQ};
  assign loopEnd = {endV[0] & endV[1] & endV[2], endV[0] & endV[1], endV[0]};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strb.clear)
    (!strb.advance && !strb.capture) |=> ($stable(outIdx) && $stable(loopEnd)))
    else $error("output moved without step"); // R4

  AST_INNER_STEP: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.advance && !loopEnd[0]) |=> (pos[0] == $past(pos[0]) + ONE_P))
    else $error("inner counter did not step"); // R3

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.advance && loopEnd == 3'b111) |=> (pos == '0))
    else $error("no wrap after nest end"); // R9

  AST_CAPTURE_FIRST: assert property (@(posedge clk) disable iff (strb.clear)
    strb.capture |=> (pos == '0))
    else $error("load did not restart walk"); // R11

endmodule

// File: rtl/remap_idx_gen.sv
module remap_idx_gen
  import remap_pkg::*;
#(
  parameter int LIM_W = 6,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LIM_W-1:0] limX,
  input  logic [LIM_W-1:0] limY,
  input  logic [LIM_W-1:0] limZ,
  input  logic [2:0]       invert,
  input  logic [2:0]       dimOrder,
  input  logic [IDX_W-1:0] baseOfs,
  input  logic             stepReq,
  output logic             outValid,
  output logic [IDX_W:0]   outIdx,
  output logic [2:0]       loopEnd
);

  strb_t strb;

  remap_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .stepReq  (stepReq),
    .strb     (strb),
    .outValid (outValid)
  );

  remap_dp #(.LIM_W(LIM_W), .IDX_W(IDX_W)) uDp (
    .clk      (clk),
    .strb     (strb),
    .limX     (limX),
    .limY     (limY),
    .limZ     (limZ),
    .invert   (invert),
    .dimOrder (dimOrder),
    .baseOfs  (baseOfs),
    .outIdx   (outIdx),
    .loopEnd  (loopEnd)
  );

endmodule

// File: tb/sim_remap_idx_gen.sv
`timescale 1ns/1ps
module sim_remap_idx_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [5:0] limX = '0, limY = '0, limZ = '0;
  logic [2:0] invert = '0, dimOrder = '0;
  logic [6:0] baseOfs = '0;
  logic       stepReq = 1'b0;
  logic       outValid;
  logic [7:0] outIdx;
  logic [2:0] loopEnd;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model of the configured shape and walk position
  int cL[3];
  int cInv, cOrd, cOfs;
  int mp[3];

  always #2 clk = ~clk;

  remap_idx_gen u0 (
    .clk(clk), .rst(rst), .load(load), .limX(limX), .limY(limY), .limZ(limZ),
    .invert(invert), .dimOrder(dimOrder), .baseOfs(baseOfs), .stepReq(stepReq),
    .outValid(outValid), .outIdx(outIdx), .loopEnd(loopEnd)
  );

  function automatic int expIdx();
    int lo, mid, hi, s;
    int v[3];
    int w[3];
    case (cOrd)
      1: begin lo = 0; mid = 2; hi = 1; end
      2: begin lo = 1; mid = 0; hi = 2; end
      3: begin lo = 1; mid = 2; hi = 0; end
      4: begin lo = 2; mid = 0; hi = 1; end
      5: begin lo = 2; mid = 1; hi = 0; end
      default: begin lo = 0; mid = 1; hi = 2; end
    endcase
    for (int d = 0; d < 3; d++) v[d] = cInv[d] ? (cL[d] - 1 - mp[d]) : mp[d];
    w[lo] = 1; w[mid] = cL[lo]; w[hi] = cL[lo] * cL[mid];
    s = 0;
    for (int d = 0; d < 3; d++) s += v[d] * w[d];
    return (s % 128) + cOfs;
  endfunction

  function automatic int expEnd();
    bit e0, e1, e2;
    e0 = (mp[0] == cL[0] - 1);
    e1 = (mp[1] == cL[1] - 1);
    e2 = (mp[2] == cL[2] - 1);
    return {29'd0, e0 & e1 & e2, e0 & e1, e0};
  endfunction

  function automatic void modelStep();
    if (mp[0] == cL[0] - 1) begin
      mp[0] = 0;
      if (mp[1] == cL[1] - 1) begin
        mp[1] = 0;
        mp[2] = (mp[2] == cL[2] - 1) ? 0 : mp[2] + 1;
      end else mp[1]++;
    end else mp[0]++;
  endfunction

  task automatic chk(input string tag);
    int ei, ee;
    ei = expIdx();
    ee = expEnd();
    nChecks++;
    if (outValid !== 1'b1 || int'(outIdx) != ei || int'(loopEnd) != ee) begin
      nFails++;
      $display("FAIL %s: valid=%0b idx=%0d end=%b, expected valid=1 idx=%0d end=%b",
               tag, outValid, outIdx, loopEnd, ei, ee[2:0]);
    end
  endtask

  task automatic chkRaw(input string tag, input bit ev, input int ei, input int ee);
    nChecks++;
    if (outValid !== ev || int'(outIdx) != ei || int'(loopEnd) != ee) begin
      nFails++;
      $display("FAIL %s: valid=%0b idx=%0d end=%b, expected valid=%0b idx=%0d end=%b",
               tag, outValid, outIdx, loopEnd, ev, ei, ee[2:0]);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic doLoad(input int lx, input int ly, input int lz, input int inv,
                        input int ord, input int ofs, input bit alsoStep, input string tag);
    load = 1'b1; stepReq = alsoStep;
    limX = 6'(lx - 1); limY = 6'(ly - 1); limZ = 6'(lz - 1);
    invert = 3'(inv); dimOrder = 3'(ord); baseOfs = 7'(ofs);
    @(negedge clk);
    load = 1'b0; stepReq = 1'b0;
    cL[0] = lx; cL[1] = ly; cL[2] = lz; cInv = inv; cOrd = ord; cOfs = ofs;
    mp[0] = 0; mp[1] = 0; mp[2] = 0;
    chk(tag);
  endtask

  task automatic doStep(input string tag);
    stepReq = 1'b1;
    @(negedge clk);
    stepReq = 1'b0;
    modelStep();
    chk(tag);
  endtask

  task automatic walk(input int n, input string tag);
    for (int i = 0; i < n; i++) doStep(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chkRaw("R1 in reset", 1'b0, 0, 7);
    rst = 1'b0;
    @(negedge clk);
    chkRaw("R1 after reset", 1'b0, 0, 7);
  endtask

  task automatic t_step_unloaded();
    stepReq = 1'b1;
    repeat (2) @(negedge clk);
    stepReq = 1'b0;
    chkRaw("R4 step before load", 1'b0, 0, 7);
  endtask

  task automatic t_basic();
    doLoad(3, 2, 4, 0, 0, 0, 1'b0, "R2 first combination");
    walk(23, "R3/R5/R8 basic walk");
    doStep("R9 wrap to start");
    walk(5, "R9 after wrap");
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R4 hold without step");
  endtask

  task automatic t_invert();
    doLoad(3, 2, 4, 5, 0, 5, 1'b0, "R6 invert X,Z load");
    walk(25, "R6/R7 invert X,Z walk");
    doLoad(4, 3, 2, 2, 3, 9, 1'b0, "R6 invert Y load");
    walk(25, "R6 invert Y walk");
  endtask

  task automatic t_orders();
    for (int o = 0; o < 8; o++) begin
      doLoad(3, 2, 4, 0, o, 0, 1'b0, (o > 5) ? "R12 order alias load" : "R5 order load");
      walk(24, (o > 5) ? "R12 order alias walk" : "R5 order walk");
    end
  endtask

  task automatic t_limit1();
    doLoad(1, 1, 5, 0, 0, 3, 1'b0, "R10 unit limits load");
    walk(6, "R10 unit limits walk");
  endtask

  task automatic t_offset();
    doLoad(4, 4, 4, 0, 1, 127, 1'b0, "R7 max offset load");
    walk(64, "R7 max offset walk");
    doLoad(8, 4, 8, 7, 4, 1, 1'b0, "R5 sum above 127 load");
    walk(256, "R5 modular sum walk");
  endtask

  task automatic t_big();
    doLoad(64, 1, 2, 1, 0, 0, 1'b0, "R3 long X load");
    walk(130, "R3/R9 long X walk");
  endtask

  task automatic t_reload();
    doLoad(3, 2, 4, 0, 0, 0, 1'b0, "R11 first shape");
    walk(5, "R11 first shape walk");
    doLoad(2, 3, 2, 6, 2, 11, 1'b1, "R11 reload beats step");
    walk(12, "R11 second shape walk");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_step_unloaded();
    t_basic();
    t_hold();
    t_invert();
    t_orders();
    t_limit1();
    t_offset();
    t_big();
    t_reload();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule